// File: doc/BRIEF.md
# Phase-Frequency Comparator with Digital Lock Detector

This block compares two pulse trains, a divided reference and a divided feedback signal, and tells an external charge pump which way to push. Both trains arrive asynchronously; each passes through a two-flop synchroniser, and its rising edges drive a classic two-flag phase-frequency comparator. A lead on the reference sets an "advance" flag. A lead on the feedback sets a "retard" flag. When both flags are set the comparison is complete, and one balanced cycle follows in which both current sources are on. This short pulse keeps the loop out of the dead zone near zero phase error. Because a flag stays set until the other edge arrives, the comparator also responds to a frequency offset and not only to a phase offset.

A polarity input reverses the sense of the pump code and swaps the two phase outputs, so the block can serve oscillators with either tuning slope. A lock judge measures each comparison's error in sample-clock cycles. It declares lock after a run of small errors and drops lock as soon as the running error grows too large. One shared output carries either the lock indicator or a synchronised copy of one of the pulse trains, which is useful for probing the dividers. A pump-enable input and a power-save input both park the pump output at high impedance. Power save also forces the lock indicator high and clears the comparator and lock state, so that work resumes from a clean state when power save is released.

Top module: `phase_lock_comparator`

## Requirements
- R1: Each pulse input is sampled by two synchroniser flops. A rising edge of the reference, first sampled at clock edge k, changes the pump code at clock edge k+4 and not earlier.
- R2: The pump code is 2'b00 for high impedance, 2'b01 for drive low, 2'b10 for drive high and 2'b11 for the balanced pulse. With polarity 1, a reference lead of L cycles gives 2'b10 for L cycles and a feedback lead gives 2'b01. Polarity 0 swaps 2'b10 and 2'b01.
- R3: When a comparison completes, the pump code is 2'b11 for exactly one cycle and then returns to 2'b00. Edges that coincide give only this single balanced cycle.
- R4: A second reference edge that arrives before the feedback edge does not end the comparison. The pump keeps driving until the feedback edge arrives, and the error count saturates instead of wrapping.
- R5: With polarity 1: on a reference lead the CMOS phase output is 0 and the open-drain output pulls low (ph_od_low=1). On a feedback lead the CMOS output is 1 and the open-drain output floats. In the equal or balanced state both are 0. Polarity 0 swaps the reference-lead and feedback-lead columns.
- R6: The lock indicator rises one cycle after the third consecutive completed comparison whose error is at most LOCK_MAX cycles.
- R7: The lock indicator falls in the cycle after the running error reaches UNLOCK_MIN cycles, before that comparison completes.
- R8: A completed comparison with an error above LOCK_MAX leaves the lock indicator unchanged but restarts the count of good comparisons.
- R9: With mon_sel=1 the shared output shows the synchronised reference level when polarity is 1, and the feedback level when polarity is 0, two cycles after sampling. With mon_sel=0 it shows the lock indicator.
- R10: When pump_en is 0 the pump code is 2'b00 from the next cycle on. The phase outputs are not affected.
- R11: When pwr_on is 0 the pump code is 2'b00 and the lock indicator reads 1. After pwr_on returns to 1, the lock indicator reads 0 until three new good comparisons have completed.
- R12: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference pulse train, asynchronous |
| fb_in | input | 1 | Feedback pulse train, asynchronous |
| polarity | input | 1 | 1: reference lead drives high; 0: reversed |
| mon_sel | input | 1 | 1: monitor a pulse train on lock_mon; 0: lock indicator |
| pump_en | input | 1 | 0 forces the pump code to high impedance |
| pwr_on | input | 1 | 0 selects power save |
| pump_code | output | 2 | Pump drive code (see R2) |
| ph_cmos | output | 1 | Push-pull phase output |
| ph_od_low | output | 1 | 1: open-drain phase output pulls low; 0: floats |
| lock_mon | output | 1 | Lock indicator or monitored pulse level |

## Verification
The bench builds the block with a 4-bit error counter and the default thresholds: good at 2 cycles or less, unlock at 4 cycles, three good comparisons for lock. The narrow counter lets a 20-cycle frequency-offset run drive the error count into saturation. The threshold pair leaves a 3-cycle error in the middle band, so the hold-and-restart rule of R8 can be exercised. Leads from 0 to 8 cycles in both directions and under both polarities cover each pump code and each column of the phase-output table.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
  typedef enum logic [1:0] {
    PUMP_HIZ    = 2'b00,
    PUMP_SINK   = 2'b01,
    PUMP_SOURCE = 2'b10,
    PUMP_BAL    = 2'b11
  } pump_code_e;
endpackage

// File: rtl/pdl_edge_sync.sv
module pdl_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
      rise    <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      last_q  <= chain_q[STAGES-1];
      rise    <= chain_q[STAGES-1] & ~last_q;
    end
  end

  assign lvl = chain_q[STAGES-1];
endmodule

// File: rtl/pdl_pfd_core.sv
module pdl_pfd_core (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic adv_q,
  output logic ret_q
);
  // Both flags set marks a finished comparison: hold them for one cycle
  // (balanced pulse), then restart with whatever edges arrive now.
  always_ff @(posedge clk) begin
    if (rst || !active) begin
      adv_q <= 1'b0;
      ret_q <= 1'b0;
    end else if (adv_q && ret_q) begin
      adv_q <= ref_rise;
      ret_q <= fb_rise;
    end else begin
      adv_q <= adv_q | ref_rise;
      ret_q <= ret_q | fb_rise;
    end
  end
endmodule

// File: rtl/pdl_lock_judge.sv
module pdl_lock_judge #(
  parameter int CNT_W      = 6,
  parameter int LOCK_MAX   = 2,
  parameter int UNLOCK_MIN = 4,
  parameter int LOCK_RUNS  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic adv,
  input  logic ret,
  output logic locked_q
);
  localparam int RUN_W = $clog2(LOCK_RUNS + 1);
  localparam logic [CNT_W:0]   UNL_V   = (CNT_W + 1)'(UNLOCK_MIN);
  localparam logic [CNT_W-1:0] GOOD_V  = CNT_W'(LOCK_MAX);
  localparam logic [CNT_W-1:0] ERR_SAT = {CNT_W{1'b1}};
  localparam logic [RUN_W:0]   RUNS_V  = (RUN_W + 1)'(LOCK_RUNS);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(LOCK_RUNS);

  logic [CNT_W-1:0] err_q;
  logic [RUN_W-1:0] run_q;
  logic [CNT_W:0]   err_inc;
  logic [RUN_W:0]   run_inc;
  logic             single, done;

  assign err_inc = {1'b0, err_q} + (CNT_W + 1)'(1);
  assign run_inc = {1'b0, run_q} + (RUN_W + 1)'(1);
  assign single  = adv ^ ret;
  assign done    = adv & ret;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      err_q    <= '0;
      run_q    <= '0;
      locked_q <= 1'b0;
    end else if (single) begin
      if (err_q != ERR_SAT) err_q <= err_inc[CNT_W-1:0];
      if (err_inc >= UNL_V) begin
        locked_q <= 1'b0;
        run_q    <= '0;
      end
    end else if (done) begin
      err_q <= '0;
      if (err_q <= GOOD_V) begin
        if (run_q != RUN_SAT) run_q <= run_inc[RUN_W-1:0];
        if (run_inc >= RUNS_V) locked_q <= 1'b1;
      end else begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/pdl_out_stage.sv
module pdl_out_stage
  import pdl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  input  logic       ret,
  input  logic       locked,
  input  logic       polarity,
  input  logic       mon_sel,
  input  logic       pump_en,
  input  logic       pwr_on,
  input  logic       ref_lvl,
  input  logic       fb_lvl,
  output logic [1:0] pump_code,
  output logic       ph_cmos,
  output logic       ph_od_low,
  output logic       lock_mon
);
  pump_code_e pump_d, pump_q;
  logic       ref_lead, fb_lead, cmos_d, od_d, lm_d;

  always_comb begin
    ref_lead = adv & ~ret;
    fb_lead  = ret & ~adv;
    if (!pwr_on || !pump_en)  pump_d = PUMP_HIZ;
    else if (adv && ret)      pump_d = PUMP_BAL;
    else if (ref_lead)        pump_d = polarity ? PUMP_SOURCE : PUMP_SINK;
    else if (fb_lead)         pump_d = polarity ? PUMP_SINK : PUMP_SOURCE;
    else                      pump_d = PUMP_HIZ;
    cmos_d = polarity ? fb_lead  : ref_lead;
    od_d   = polarity ? ref_lead : fb_lead;
    if (mon_sel)      lm_d = polarity ? ref_lvl : fb_lvl;
    else if (!pwr_on) lm_d = 1'b1;
    else              lm_d = locked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pump_q    <= PUMP_HIZ;
      ph_cmos   <= 1'b0;
      ph_od_low <= 1'b0;
      lock_mon  <= 1'b0;
    end else begin
      pump_q    <= pump_d;
      ph_cmos   <= cmos_d;
      ph_od_low <= od_d;
      lock_mon  <= lm_d;
    end
  end

  assign pump_code = pump_q;
endmodule

// File: rtl/phase_lock_comparator.sv
module phase_lock_comparator #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6,
  parameter int LOCK_MAX    = 2,
  parameter int UNLOCK_MIN  = 4,
  parameter int LOCK_RUNS   = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_in,
  input  logic       fb_in,
  input  logic       polarity,
  input  logic       mon_sel,
  input  logic       pump_en,
  input  logic       pwr_on,
  output logic [1:0] pump_code,
  output logic       ph_cmos,
  output logic       ph_od_low,
  output logic       lock_mon
);
  localparam int N_IN = 2;

  logic [N_IN-1:0] raw_in, lvl, rise;
  logic            adv, ret, locked;

  assign raw_in = {fb_in, ref_in};

  for (genvar i = 0; i < N_IN; i++) begin : g_sync
    pdl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (raw_in[i]),
      .lvl (lvl[i]),
      .rise(rise[i])
    );
  end

  pdl_pfd_core u_core (
    .clk     (clk),
    .rst     (rst),
    .active  (pwr_on),
    .ref_rise(rise[0]),
    .fb_rise (rise[1]),
    .adv_q   (adv),
    .ret_q   (ret)
  );

  pdl_lock_judge #(
    .CNT_W     (CNT_W),
    .LOCK_MAX  (LOCK_MAX),
    .UNLOCK_MIN(UNLOCK_MIN),
    .LOCK_RUNS (LOCK_RUNS)
  ) u_judge (
    .clk     (clk),
    .rst     (rst),
    .active  (pwr_on),
    .adv     (adv),
    .ret     (ret),
    .locked_q(locked)
  );

  pdl_out_stage u_out (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .ret      (ret),
    .locked   (locked),
    .polarity (polarity),
    .mon_sel  (mon_sel),
    .pump_en  (pump_en),
    .pwr_on   (pwr_on),
    .ref_lvl  (lvl[0]),
    .fb_lvl   (lvl[1]),
    .pump_code(pump_code),
    .ph_cmos  (ph_cmos),
    .ph_od_low(ph_od_low),
    .lock_mon (lock_mon)
  );
endmodule

// File: rtl/phase_lock_comparator_chk.sv
module phase_lock_comparator_chk (
  input logic       clk,
  input logic       rst,
  input logic       mon_sel,
  input logic       pump_en,
  input logic       pwr_on,
  input logic [1:0] pump_code,
  input logic       ph_cmos,
  input logic       ph_od_low,
  input logic       lock_mon
);
  p_balance_single_r3: assert property (@(posedge clk) disable iff (rst)
    (pump_code == 2'b11) |=> (pump_code != 2'b11));

  p_phase_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    ph_od_low |-> !ph_cmos);

  p_disable_hiz_r10: assert property (@(posedge clk) disable iff (rst)
    !pump_en |=> (pump_code == 2'b00));

  p_save_hiz_r11: assert property (@(posedge clk) disable iff (rst)
    !pwr_on |=> (pump_code == 2'b00));

  p_save_lock_high_r11: assert property (@(posedge clk) disable iff (rst)
    (!pwr_on && !mon_sel) |=> lock_mon);
endmodule

bind phase_lock_comparator phase_lock_comparator_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .mon_sel  (mon_sel),
  .pump_en  (pump_en),
  .pwr_on   (pwr_on),
  .pump_code(pump_code),
  .ph_cmos  (ph_cmos),
  .ph_od_low(ph_od_low),
  .lock_mon (lock_mon)
);

// File: tb/phase_lock_comparator_test.sv
module phase_lock_comparator_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW   = 4;
  localparam int CMAX = 15;
  localparam int LMAX = 2;
  localparam int UNL  = 4;
  localparam int RUNS = 3;
  localparam int NT   = 48;
  localparam int PW   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0, fb_in = 1'b0, polarity = 1'b1, mon_sel = 1'b0;
  logic pump_en = 1'b1, pwr_on = 1'b1;
  logic [1:0] pump_code;
  logic ph_cmos, ph_od_low, lock_mon;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_lock_comparator #(.CNT_W(CW), .LOCK_MAX(LMAX), .UNLOCK_MIN(UNL), .LOCK_RUNS(RUNS)) uut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in), .polarity(polarity),
    .mon_sel(mon_sel), .pump_en(pump_en), .pwr_on(pwr_on), .pump_code(pump_code),
    .ph_cmos(ph_cmos), .ph_od_low(ph_od_low), .lock_mon(lock_mon));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: sample histories, two event flags, an error tally.
  bit rh[3], fh[3];
  bit m_rp, m_fp, m_up, m_dn, m_lock;
  int m_err, m_run;
  int e_pump, e_cmos, e_od, e_lm;

  always @(posedge clk) begin
    if (rst) begin
      foreach (rh[i]) begin rh[i] = 0; fh[i] = 0; end
      m_rp = 0; m_fp = 0; m_up = 0; m_dn = 0; m_lock = 0; m_err = 0; m_run = 0;
      e_pump = 0; e_cmos = 0; e_od = 0; e_lm = 0;
    end else begin
      // outputs from the state held before this edge
      if (!pwr_on || !pump_en) e_pump = 0;
      else if (m_up && m_dn)   e_pump = 3;
      else if (m_up)           e_pump = polarity ? 2 : 1;
      else if (m_dn)           e_pump = polarity ? 1 : 2;
      else                     e_pump = 0;
      e_cmos = polarity ? int'(m_dn && !m_up) : int'(m_up && !m_dn);
      e_od   = polarity ? int'(m_up && !m_dn) : int'(m_dn && !m_up);
      if (mon_sel)      e_lm = polarity ? int'(rh[1]) : int'(fh[1]);
      else if (!pwr_on) e_lm = 1;
      else              e_lm = int'(m_lock);
      // lock tally
      if (!pwr_on) begin
        m_err = 0; m_run = 0; m_lock = 0;
      end else if (m_up != m_dn) begin
        if (m_err + 1 >= UNL) begin m_lock = 0; m_run = 0; end
        if (m_err < CMAX) m_err++;
      end else if (m_up && m_dn) begin
        if (m_err <= LMAX) begin
          if (m_run + 1 >= RUNS) m_lock = 1;
          if (m_run < RUNS) m_run++;
        end else m_run = 0;
        m_err = 0;
      end
      // event flags
      if (!pwr_on) begin m_up = 0; m_dn = 0; end
      else if (m_up && m_dn) begin m_up = m_rp; m_dn = m_fp; end
      else begin m_up = m_up | m_rp; m_dn = m_dn | m_fp; end
      m_rp = rh[1] && !rh[2];
      m_fp = fh[1] && !fh[2];
      rh[2] = rh[1]; rh[1] = rh[0]; rh[0] = ref_in;
      fh[2] = fh[1]; fh[1] = fh[0]; fh[0] = fb_in;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R2 pump code vs model", int'(pump_code), e_pump);
      chk("R5 cmos phase vs model", int'(ph_cmos), e_cmos);
      chk("R5 open-drain phase vs model", int'(ph_od_low), e_od);
      chk("R6 lock/monitor vs model", int'(lock_mon), e_lm);
    end
  end

  int tr_p[NT], tr_c[NT], tr_o[NT], tr_l[NT];

  // tr_*[j] holds the outputs after clock edge k+j; sample index 0 is edge k.
  task automatic run_seq(input int r0, input int r1, input int f0);
    for (int t = 0; t <= NT; t++) begin
      @(negedge clk);
      if (t > 0) begin
        tr_p[t-1] = int'(pump_code); tr_c[t-1] = int'(ph_cmos);
        tr_o[t-1] = int'(ph_od_low); tr_l[t-1] = int'(lock_mon);
      end
      ref_in = (t >= r0 && t < r0 + PW) || (r1 >= 0 && t >= r1 && t < r1 + PW);
      fb_in  = (t >= f0 && t < f0 + PW);
    end
    ref_in = 0; fb_in = 0;
  endtask

  task automatic pair(input int lead);
    if (lead >= 0) run_seq(0, -1, lead);
    else           run_seq(-lead, -1, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R12 reset pump", int'(pump_code), 0);
    chk("R12 reset cmos", int'(ph_cmos), 0);
    chk("R12 reset od", int'(ph_od_low), 0);
    chk("R12 reset lock", int'(lock_mon), 0);
    rst = 0;
    repeat (3) @(negedge clk);

    pair(5);
    chk("R1 no change at k+3", tr_p[3], 0);
    chk("R1 drive at k+4", tr_p[4], 2);
    chk("R2 ref lead pol1 high", tr_p[8], 2);
    chk("R3 balance after lead", tr_p[9], 3);
    chk("R3 hiz after balance", tr_p[10], 0);
    chk("R5 ref lead pol1 cmos", tr_c[5], 0);
    chk("R5 ref lead pol1 od", tr_o[5], 1);
    pair(-5);
    chk("R2 fb lead pol1 low", tr_p[5], 1);
    chk("R5 fb lead pol1 cmos", tr_c[5], 1);
    chk("R5 fb lead pol1 od", tr_o[5], 0);
    polarity = 0;
    pair(5);
    chk("R2 ref lead pol0 low", tr_p[5], 1);
    chk("R5 ref lead pol0 cmos", tr_c[5], 1);
    chk("R5 ref lead pol0 od", tr_o[5], 0);
    pair(-5);
    chk("R2 fb lead pol0 high", tr_p[5], 2);
    chk("R5 fb lead pol0 cmos", tr_c[5], 0);
    chk("R5 fb lead pol0 od", tr_o[5], 1);
    polarity = 1;

    pair(0);
    chk("R3 coincident idle before", tr_p[3], 0);
    chk("R3 coincident balance", tr_p[4], 3);
    chk("R3 coincident one cycle", tr_p[5], 0);
    chk("R5 equal cmos", tr_c[4], 0);
    chk("R5 equal od", tr_o[4], 0);
    pair(1);
    chk("R6 two good not locked", tr_l[20], 0);
    pair(2);
    chk("R6 not yet at compare", tr_l[6], 0);
    chk("R6 locked after third", tr_l[7], 1);

    pair(3);
    chk("R8 mid error holds lock", tr_l[20], 1);
    pair(8);
    chk("R7 lock held before threshold", tr_l[7], 1);
    chk("R7 lock drops early", tr_l[8], 0);
    chk("R7 pump still driving", tr_p[8], 2);

    pair(1); pair(1); pair(3); pair(1); pair(1);
    chk("R8 streak restarted", tr_l[20], 0);
    pair(2);
    chk("R8 lock after fresh streak", tr_l[20], 1);

    run_seq(0, 10, 20);
    chk("R4 driving at start", tr_p[4], 2);
    chk("R4 second ref edge ignored", tr_p[16], 2);
    chk("R4 driving until feedback", tr_p[23], 2);
    chk("R4 balance on feedback", tr_p[24], 3);
    chk("R4 lock lost on offset", tr_l[30], 0);

    mon_sel = 1;
    pair(6);
    chk("R9 ref monitor before", tr_l[1], 0);
    chk("R9 ref monitor high", tr_l[2], 1);
    chk("R9 ref monitor ignores fb", tr_l[8], 0);
    polarity = 0;
    pair(6);
    chk("R9 fb monitor ignores ref", tr_l[2], 0);
    chk("R9 fb monitor high", tr_l[8], 1);
    mon_sel = 0; polarity = 1;

    pump_en = 0;
    pair(6);
    chk("R10 disabled pump hiz", tr_p[6], 0);
    chk("R10 disabled pump hiz late", tr_p[10], 0);
    chk("R10 phase output unaffected", tr_o[6], 1);
    pump_en = 1;

    pair(1); pair(1); pair(1);
    chk("R6 relock", tr_l[20], 1);
    pwr_on = 0;
    pair(3);
    chk("R11 save lock high", tr_l[1], 1);
    chk("R11 save pump hiz", tr_p[6], 0);
    pwr_on = 1;
    pair(1);
    chk("R11 lock cleared on release", tr_l[0], 0);
    chk("R11 one good after release", tr_l[20], 0);
    pair(1);
    chk("R11 two good after release", tr_l[20], 0);
    pair(1);
    chk("R11 relock after release", tr_l[20], 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule